// File: doc/BRIEF.md
# Overcurrent Three-Strike Fault Sequencer

This block supervises the two gate enables of a synchronous buck power stage. It takes a synchronous internal PWM command, an overcurrent comparator flag, a below-half-current comparator flag, an enable input and an active-low power-on reset. The PWM high level asks for the high-side switch, and the PWM low level asks for the low-side switch. From these it drives the high-side and low-side gate enables. It also reports a latched fault and the number of consecutive overcurrent trips.

Each low-side interval has a guaranteed minimum width. The overcurrent flag is only considered after a blanking delay at the start of that interval. When a trip is seen, the high side is kept off and the low side is held on until the current has fallen below half the trip level. Switching then resumes. Three consecutive trips shut both switches off until the enable input is cycled low and then high, or until the power-on reset is applied. Any monitored low-side interval that ends without a trip clears the trip count. Both delays are set in nanoseconds and are converted into clock cycles from the clock frequency parameter. At the defaults (125 MHz) the blanking delay is 25 cycles and the minimum low-side width is 38 cycles.

Top module: `ocp_strike_seq`

## Requirements
- R1: While `rst_n` is low, or on the cycle after `enable_i` was sampled low, both gate enables are 0, `fault_latched_o` is 0 and `strike_cnt_o` is 0.
- R2: The two gate enables are never both 1. `hs_en_o` rises only after `ls_en_o` has been 1 for at least MIN_LS cycles in a row (38 at defaults), and only while `pwm_i` is 1.
- R3: `oc_trip_i` is ignored during the first BLANK cycles (25 at defaults) of each low-side interval, counted from the cycle the interval begins. It is also ignored while the high side is enabled.
- R4: An `oc_trip_i` sampled inside the monitoring window raises `strike_cnt_o` by one on the next cycle. If the count is then below three, the next cycle also shows `hs_en_o`=0 and `ls_en_o`=1.
- R5: After a trip, `ls_en_o` stays 1 and `hs_en_o` stays 0 whatever `pwm_i` does, until `half_ok_i` is sampled 1. Normal switching then resumes in a fresh low-side interval.
- R6: The first low-side interval after a hold is not monitored. Monitoring resumes with the next low-side interval.
- R7: The trip that brings the count to three sets `fault_latched_o`=1 and drives both gate enables to 0. This state holds for as long as `enable_i` stays 1.
- R8: A monitored low-side interval that ends without a trip clears `strike_cnt_o` to 0.
- R9: A latched fault clears only through `rst_n` or through `enable_i` going low and then high. Re-enabling starts with a count of 0, `ls_en_o`=1 and `hs_en_o`=0.
- R10: The first low-side interval after enable (the soft-start) is monitored, and its trips count toward the three-strike limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| enable_i | input | 1 | Converter enable; low shuts down and clears state |
| pwm_i | input | 1 | Internal PWM command, 1 = high side, 0 = low side |
| oc_trip_i | input | 1 | Overcurrent comparator flag |
| half_ok_i | input | 1 | 1 when current is below half the trip level |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| fault_latched_o | output | 1 | Three-strike latch-off status |
| strike_cnt_o | output | STRIKE_W (2) | Consecutive trip count |

## Verification
The hardest state to reach is a latch-off that really comes from three trips in a row. A trip only counts inside a narrow window late in an armed low-side interval. Every recovery leaves one unarmed interval, and one clean interval in between resets the count. Directed sequences therefore place each trip a known number of cycles after a low-side start. They also hold the comparator high through the unarmed interval, to show that those edges are not counted. Random PWM periods, trip densities and release timing, with occasional enable pulses and resets, then reach the remaining interleavings. A cycle-level expectation model built from the requirements checks every output on every cycle.

// File: rtl/ocp_seq_pkg.sv
package ocp_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_OFF   = 2'd0,
      SEQ_RUN   = 2'd1,
      SEQ_HOLD  = 2'd2,
      SEQ_LATCH = 2'd3
   } seq_mode_t;

   // Rounds a delay in ns up to whole clock cycles for a clock given in kHz.
   function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                input int unsigned clk_khz);
      longint unsigned prod;
      prod = longint'(ns) * longint'(clk_khz);
      return int'((prod + 64'd999_999) / 64'd1_000_000);
   endfunction

endpackage

// File: rtl/ocp_in_stage.sv
module ocp_in_stage #(
   parameter int STAGES = 0,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES == 0) begin : g_direct
         assign q_o = d_i;
      end else begin : g_flops
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= d_i;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q_o = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/ocp_ls_timer.sv
module ocp_ls_timer #(
   parameter int BLANK_CYC  = 25,
   parameter int MIN_LS_CYC = 38,
   parameter int CNT_W      = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic pwm_i,
   output logic lo_phase_o,
   output logic window_o,
   output logic lo_end_o
);

   localparam logic [CNT_W-1:0] BLANK_V = CNT_W'(BLANK_CYC);
   localparam logic [CNT_W-1:0] LAST_V  = CNT_W'(MIN_LS_CYC - 1);

   logic             lo_q;
   logic [CNT_W-1:0] cnt_q;
   logic             min_met;

   assign min_met    = (cnt_q >= LAST_V);
   assign lo_phase_o = lo_q;
   assign window_o   = lo_q && (cnt_q >= BLANK_V);
   assign lo_end_o   = lo_q && pwm_i && min_met;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q  <= 1'b1;
         cnt_q <= '0;
      end else if (!run_i) begin
         lo_q  <= 1'b1;
         cnt_q <= '0;
      end else if (lo_q) begin
         if (lo_end_o) begin
            lo_q  <= 1'b0;
            cnt_q <= '0;
         end else if (!min_met) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else if (!pwm_i) begin
         lo_q  <= 1'b1;
         cnt_q <= '0;
      end
   end

endmodule

// File: rtl/ocp_strike_fsm.sv
module ocp_strike_fsm
   import ocp_seq_pkg::*;
#(
   parameter int STRIKE_LIMIT = 3,
   parameter int STRIKE_W     = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en_i,
   input  logic                oc_i,
   input  logic                half_ok_i,
   input  logic                window_i,
   input  logic                lo_end_i,
   output seq_mode_t           mode_o,
   output logic [STRIKE_W-1:0] strike_o
);

   localparam logic [STRIKE_W-1:0] LIMIT_V = STRIKE_W'(STRIKE_LIMIT);

   seq_mode_t           mode_q;
   logic [STRIKE_W-1:0] strike_q;
   logic [STRIKE_W-1:0] strike_nxt;
   logic                armed_q;
   logic                trip;

   assign trip       = (mode_q == SEQ_RUN) && armed_q && window_i && oc_i;
   assign strike_nxt = strike_q + 1'b1;
   assign mode_o     = mode_q;
   assign strike_o   = strike_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= SEQ_OFF;
         strike_q <= '0;
         armed_q  <= 1'b0;
      end else if (!en_i) begin
         mode_q   <= SEQ_OFF;
         strike_q <= '0;
         armed_q  <= 1'b0;
      end else begin
         unique case (mode_q)
            SEQ_OFF: begin
               mode_q   <= SEQ_RUN;
               strike_q <= '0;
               armed_q  <= 1'b1;
            end
            SEQ_RUN: begin
               if (trip) begin
                  strike_q <= strike_nxt;
                  mode_q   <= (strike_nxt == LIMIT_V) ? SEQ_LATCH : SEQ_HOLD;
               end else if (lo_end_i) begin
                  if (armed_q) strike_q <= '0;
                  armed_q <= 1'b1;
               end
            end
            SEQ_HOLD: begin
               if (half_ok_i) begin
                  mode_q  <= SEQ_RUN;
                  armed_q <= 1'b0;
               end
            end
            SEQ_LATCH: begin
               mode_q <= SEQ_LATCH;
            end
            default: mode_q <= SEQ_OFF;
         endcase
      end
   end

endmodule

// File: rtl/ocp_strike_seq.sv
module ocp_strike_seq
   import ocp_seq_pkg::*;
#(
   parameter int CLK_KHZ      = 125_000,
   parameter int BLANK_NS     = 200,
   parameter int MIN_LS_NS    = 300,
   parameter int STRIKE_LIMIT = 3,
   parameter int IN_STAGES    = 0,
   localparam int BLANK_CYC   = int'(ns_to_cycles(BLANK_NS, CLK_KHZ)),
   localparam int MIN_LS_CYC  = int'(ns_to_cycles(MIN_LS_NS, CLK_KHZ)),
   localparam int CNT_W       = $clog2(MIN_LS_CYC + 1),
   localparam int STRIKE_W    = $clog2(STRIKE_LIMIT + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable_i,
   input  logic                pwm_i,
   input  logic                oc_trip_i,
   input  logic                half_ok_i,
   output logic                hs_en_o,
   output logic                ls_en_o,
   output logic                fault_latched_o,
   output logic [STRIKE_W-1:0] strike_cnt_o
);

   generate
      if (MIN_LS_CYC <= BLANK_CYC) begin : g_bad_window
         $error("minimum low-side width must exceed the blanking delay");
      end
      if (STRIKE_LIMIT < 1) begin : g_bad_limit
         $error("strike limit must be at least one");
      end
      if (IN_STAGES < 0) begin : g_bad_stages
         $error("input stage count must not be negative");
      end
   endgenerate

   logic [2:0] raw_in;
   logic [2:0] stg_in;
   logic       pwm_s, oc_s, half_s;
   logic       lo_phase, window, lo_end;
   seq_mode_t  mode;
   logic       run;

   assign raw_in = {pwm_i, oc_trip_i, half_ok_i};
   assign {pwm_s, oc_s, half_s} = stg_in;
   assign run = (mode == SEQ_RUN);

   ocp_in_stage #(
      .STAGES (IN_STAGES),
      .W      (3)
   ) u_in_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (stg_in)
   );

   ocp_ls_timer #(
      .BLANK_CYC  (BLANK_CYC),
      .MIN_LS_CYC (MIN_LS_CYC),
      .CNT_W      (CNT_W)
   ) u_ls_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run),
      .pwm_i      (pwm_s),
      .lo_phase_o (lo_phase),
      .window_o   (window),
      .lo_end_o   (lo_end)
   );

   ocp_strike_fsm #(
      .STRIKE_LIMIT (STRIKE_LIMIT),
      .STRIKE_W     (STRIKE_W)
   ) u_strike_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (enable_i),
      .oc_i      (oc_s),
      .half_ok_i (half_s),
      .window_i  (window),
      .lo_end_i  (lo_end),
      .mode_o    (mode),
      .strike_o  (strike_cnt_o)
   );

   assign hs_en_o         = run && !lo_phase;
   assign ls_en_o         = (run && lo_phase) || (mode == SEQ_HOLD);
   assign fault_latched_o = (mode == SEQ_LATCH);

endmodule

// File: rtl/ocp_strike_seq_chk.sv
module ocp_strike_seq_chk #(
   parameter int MIN_LS_CYC = 38,
   parameter int STRIKE_W   = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                enable_i,
   input logic                hs_en_o,
   input logic                ls_en_o,
   input logic                fault_latched_o,
   input logic [STRIKE_W-1:0] strike_cnt_o
);

   localparam int LW = $clog2(MIN_LS_CYC + 2);
   localparam logic [LW-1:0] LCAP = LW'(MIN_LS_CYC + 1);
   localparam logic [LW-1:0] LMIN = LW'(MIN_LS_CYC);

   logic [LW-1:0] ls_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        ls_len <= '0;
      else if (!ls_en_o)                 ls_len <= '0;
      else if (ls_len != LCAP)           ls_len <= ls_len + 1'b1;
   end

   // R1 R9
   disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> (!hs_en_o && !ls_en_o && !fault_latched_o && strike_cnt_o == '0));

   // R2
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_en_o && ls_en_o));

   // R2
   min_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_en_o) |-> (ls_len >= LMIN));

   // R4
   strike_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strike_cnt_o > $past(strike_cnt_o)) |-> !hs_en_o);

   // R7
   latch_gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_latched_o |-> (!hs_en_o && !ls_en_o));

   // R7
   latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_latched_o && enable_i) |=> fault_latched_o);

endmodule

bind ocp_strike_seq ocp_strike_seq_chk #(
   .MIN_LS_CYC (MIN_LS_CYC),
   .STRIKE_W   (STRIKE_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .enable_i        (enable_i),
   .hs_en_o         (hs_en_o),
   .ls_en_o         (ls_en_o),
   .fault_latched_o (fault_latched_o),
   .strike_cnt_o    (strike_cnt_o)
);

// File: tb/ocp_strike_seq_bench.sv
module ocp_strike_seq_bench;

   localparam int CLK_KHZ   = 125_000;
   localparam int BLANK_C   = (200 * CLK_KHZ + 999_999) / 1_000_000; // 25
   localparam int MIN_C     = (300 * CLK_KHZ + 999_999) / 1_000_000; // 38
   localparam int M_OFF = 0, M_RUN = 1, M_HOLD = 2, M_LATCH = 3;

   logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
   logic pwm = 1'b0, trip = 1'b0, half = 1'b0;
   logic hs, ls, fault;
   logic [1:0] strike;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   int m_st, m_cnt, m_strike;
   bit m_lo, m_armed;

   always #4 clk = ~clk;

   ocp_strike_seq u_ocp_strike_seq (
      .clk             (clk),
      .rst_n           (rst_n),
      .enable_i        (enable),
      .pwm_i           (pwm),
      .oc_trip_i       (trip),
      .half_ok_i       (half),
      .hs_en_o         (hs),
      .ls_en_o         (ls),
      .fault_latched_o (fault),
      .strike_cnt_o    (strike)
   );

   // Expectation model written from the requirements.
   always @(posedge clk or negedge rst_n) begin
      bit running, in_win, ends, hit;
      if (!rst_n) begin
         m_st = M_OFF; m_lo = 1; m_cnt = 0; m_armed = 0; m_strike = 0;
      end else begin
         running = (m_st == M_RUN);
         in_win  = m_lo && (m_cnt >= BLANK_C);
         ends    = m_lo && pwm && (m_cnt >= MIN_C - 1);
         hit     = running && m_armed && in_win && trip;
         if (!running) begin m_lo = 1; m_cnt = 0; end
         else if (m_lo) begin
            if (ends) begin m_lo = 0; m_cnt = 0; end
            else if (m_cnt < MIN_C - 1) m_cnt++;
         end else if (!pwm) begin m_lo = 1; m_cnt = 0; end
         if (!enable) begin m_st = M_OFF; m_strike = 0; m_armed = 0; end
         else if (m_st == M_OFF) begin m_st = M_RUN; m_strike = 0; m_armed = 1; end
         else if (m_st == M_RUN) begin
            if (hit) begin
               m_strike++;
               m_st = (m_strike == 3) ? M_LATCH : M_HOLD;
            end else if (ends) begin
               if (m_armed) m_strike = 0;
               m_armed = 1;
            end
         end else if (m_st == M_HOLD) begin
            if (half) begin m_st = M_RUN; m_armed = 0; end
         end
      end
   end

   task automatic chk(input string tag, input bit ok, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic cmp_model();
      int e_hs, e_ls, e_f;
      string tag;
      e_hs = (m_st == M_RUN) && !m_lo;
      e_ls = ((m_st == M_RUN) && m_lo) || (m_st == M_HOLD);
      e_f  = (m_st == M_LATCH);
      case (m_st)
         M_OFF:   tag = "R1";
         M_HOLD:  tag = "R5";
         M_LATCH: tag = "R7";
         default: tag = "R2";
      endcase
      chk(tag, {hs, ls, fault} == {e_hs[0], e_ls[0], e_f[0]}, "gates{hs,ls,fault}",
          {hs, ls, fault}, {e_hs[0], e_ls[0], e_f[0]});
      chk("R8", int'(strike) == m_strike, "strike_cnt", strike, m_strike);
   endtask

   task automatic tick(input bit p, input bit t, input bit h);
      pwm = p; trip = t; half = h;
      @(posedge clk);
      @(negedge clk);
      cmp_model();
   endtask

   // Waits out the blanking, then trips once inside the window.
   task automatic trip_in_window();
      for (int i = 0; i < BLANK_C + 4; i++) tick(0, 0, 0);
      tick(0, 1, 0);
   endtask

   initial begin
      repeat (200_000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int per, hi, dens;
      bit p, t, h;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R1", {hs, ls, fault, strike} == 5'b0, "reset outputs", {hs, ls, fault, strike}, 0);
      rst_n = 1'b1;
      tick(0, 0, 0);
      chk("R1", {hs, ls} == 2'b00, "disabled gates", {hs, ls}, 0);
      enable = 1'b1;
      tick(0, 0, 0);
      chk("R9", {hs, ls} == 2'b01 && strike == 0, "enable start", {hs, ls, strike}, 4);

      // R3: trip inside the blanking period is ignored
      for (int i = 0; i < 20; i++) tick(0, 1, 0);
      chk("R3", strike == 0 && ls, "blanked trip", strike, 0);
      for (int i = 0; i < 9; i++) tick(0, 0, 0);
      // R10 + R4: soft-start interval is monitored
      tick(0, 1, 0);
      chk("R10", strike == 1, "first-interval trip", strike, 1);
      chk("R4", {hs, ls} == 2'b01, "hold after trip", {hs, ls}, 1);

      // R5: held with PWM high until half flag
      for (int i = 0; i < 50; i++) tick(1, 0, 0);
      chk("R5", {hs, ls} == 2'b01, "hold while current high", {hs, ls}, 1);
      tick(1, 0, 1);
      // R2 + R6: fresh low interval, unmonitored even with trip high
      for (int i = 0; i < MIN_C - 1; i++) tick(1, 1, 0);
      chk("R2", {hs, ls} == 2'b01, "min width not yet met", {hs, ls}, 1);
      tick(1, 1, 0);
      chk("R2", {hs, ls} == 2'b10, "high side after min width", {hs, ls}, 2);
      chk("R6", strike == 1, "unarmed interval ignored", strike, 1);

      // second and third consecutive trips
      tick(0, 0, 0);
      trip_in_window();
      chk("R4", strike == 2, "second trip", strike, 2);
      tick(1, 0, 1);
      for (int i = 0; i < MIN_C; i++) tick(1, 0, 0);
      tick(0, 0, 0);
      trip_in_window();
      chk("R7", fault && {hs, ls} == 2'b00 && strike == 3, "latch-off", {fault, hs, ls}, 4);
      for (int i = 0; i < 100; i++) tick(1'($urandom), 1'($urandom), 1'($urandom));
      chk("R7", fault && {hs, ls} == 2'b00, "latch holds", {fault, hs, ls}, 4);

      // R9: enable toggle clears the latch
      enable = 1'b0; tick(0, 0, 0);
      chk("R1", !fault && strike == 0, "disable clears", {fault, strike}, 0);
      enable = 1'b1; tick(0, 0, 0);
      chk("R9", !fault && strike == 0 && ls && !hs, "restart", {fault, strike, hs, ls}, 1);
      trip_in_window();
      chk("R10", strike == 1, "soft-start trip", strike, 1);
      tick(1, 0, 1);
      for (int i = 0; i < MIN_C; i++) tick(1, 0, 0);
      tick(0, 0, 0);
      for (int i = 0; i < 40; i++) tick(0, 0, 0);
      chk("R8", strike == 1, "count kept during clean interval", strike, 1);
      tick(1, 0, 0);
      chk("R8", strike == 0 && hs, "clean interval clears", strike, 0);

      // random phase
      for (int b = 0; b < 40; b++) begin
         per  = 60 + $urandom_range(100);
         hi   = $urandom_range(per * 3 / 4, 5);
         dens = $urandom_range(3);
         for (int c = 0; c < per * 5; c++) begin
            p = (c % per) < hi;
            t = (dens != 0) && ($urandom_range(9) < dens * 2);
            h = ($urandom_range(15) == 0);
            if ($urandom_range(499) == 0) begin
               rst_n = 1'b0; tick(p, t, h); rst_n = 1'b1;
               chk("R1", {hs, ls, fault} == 3'b000, "after reset", {hs, ls, fault}, 0);
            end else if ($urandom_range(299) == 0) begin
               enable = 1'b0; tick(p, t, h); enable = 1'b1;
            end else begin
               tick(p, t, h);
            end
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule